// File: doc/BRIEF.md
# Streaming radix-2 delay-feedback transform stage (modulo 3329)

This block is one stage of a streaming radix-2 number theoretic transform over 12-bit coefficients modulo 3329. Coefficients arrive one per accepted cycle, marked by `in_valid`, and leave one per accepted cycle. The stream is cut into blocks of `N` samples. The first half of each block is held in a delay path. Each sample of the second half is then paired with the sample `N/2` positions earlier and passed through a Cooley-Tukey butterfly. The sum goes out at once. The difference is fed back into delay storage and leaves during the first half of the next block.

The butterfly has a pipeline latency `LAT`, so the stage uses four delay lines instead of one `N/2` line. Incoming samples pass through a line of depth `N/2-LAT` and then a short line of depth `LAT`. Fed-back differences pass through a line of depth `N/2-2*LAT`, then through the same short line during the cycles when it is idle, and then through a final line of depth `LAT`. A local phase counter drives every select. A block counter picks the twiddle factor from a small ROM that is computed when the design is built.

Moving the stream forward is tied to `in_valid`. A cycle without `in_valid` freezes the stage completely, so blocks can be streamed back to back or with gaps. Either way the results are the same.

Top module: `ntt_sdf_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_data` is 0. `out_data` keeps its value between valid outputs.
- R2: Output sample k appears on the cycle after input sample k+N/2+LAT is accepted. The first N/2+LAT accepted inputs produce no valid output.
- R3: For a block x[0..N-1] with twiddle w, output j for j < N/2 is (x[j] + w*x[j+N/2]) mod 3329.
- R4: Output N/2+j of the same block is (x[j] - w*x[j+N/2]) mod 3329, reduced into 0..3328.
- R5: Block b (counted from reset, starting at 0) uses twiddle t[b mod TW_NUM], where t[k] = TW_ROOT^(TW_EXP0 + TW_STEP*k) mod 3329.
- R6: Once primed, every accepted input produces exactly one valid output on the next cycle. Consecutive blocks stream with no dead cycles between them.
- R7: A cycle with `in_valid` low advances no state. `in_data` is ignored on that cycle, and `out_valid` is 0 on the next cycle.
- R8: The shared short delay line never receives first-half data and fed-back data on the same step. Each step it receives exactly one of the two, and the selected source is the one carrying live data.
- R9: For inputs in 0..3328, including the extremes 0 and 3328, every valid output lies in 0..3328.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is accepted this cycle; also advances the stage |
| in_data | input | 12 | Input coefficient, 0..3328 |
| out_valid | output | 1 | `out_data` holds a new output sample |
| out_data | output | 12 | Output coefficient (registered) |

## Verification
The bench streams twelve 16-sample blocks through a small stage with a two-cycle butterfly. It uses all-zero, all-3328, alternating-extreme, single-impulse, ramp and pseudo-random blocks, and it cycles through four twiddles. A wrong delay depth or a misplaced phase window would pair samples from the wrong distance or emit the fed-back difference a block early, and every second-half output would then mismatch. An error in the twiddle schedule shows up only in blocks 1, 2 and 3 of each group of four. The last four blocks are sent with irregular idle cycles that carry junk data. A stage that advanced while idle, or that accepted the junk, would shift or corrupt its outputs and raise `out_valid` in an idle cycle. The bench also checks the exact cycle of the first valid output and the final output count, so both a late start and a lost sample are caught.

// File: rtl/ntt_sdf_pkg.sv
`timescale 1ns/1ps
package ntt_sdf_pkg;

  localparam int unsigned MODQ = 3329;
  localparam int          CW   = 12;

  typedef logic [CW-1:0] coef_t;

  // base^e mod MODQ, evaluated at elaboration for the twiddle table
  function automatic int unsigned mod_pow(input int unsigned base, input int unsigned e);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) begin
      r = (r * (base % MODQ)) % MODQ;
    end
    return r;
  endfunction

endpackage

// File: rtl/ntt_sdf_dline.sv
`timescale 1ns/1ps
// Fixed delay line that advances on en: dout at step t equals din of step t-D.
module ntt_sdf_dline #(
  parameter int W = 12,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int SHIFT_MAX = 4;

  generate
    if (D == 0) begin : g_wire
      assign dout = din;
    end else if (D <= SHIFT_MAX) begin : g_shift
      logic [W-1:0] sr [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < D; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= din;
          for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
        end
      end
      assign dout = sr[D-1];
    end else begin : g_ram
      localparam int MD = D - 1;
      localparam int AW = (MD > 1) ? $clog2(MD) : 1;
      logic [W-1:0]  mem [MD];
      logic [AW-1:0] ptr;
      logic [W-1:0]  rd_q;
      // one read and one write per step at the same address (read-first)
      always_ff @(posedge clk) begin
        if (en) begin
          mem[ptr] <= din;
        end
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          ptr  <= '0;
          rd_q <= '0;
        end else if (en) begin
          rd_q <= mem[ptr];
          ptr  <= (ptr == AW'(MD - 1)) ? '0 : ptr + 1'b1;
        end
      end
      assign dout = rd_q;
    end
  endgenerate

endmodule

// File: rtl/ntt_sdf_twrom.sv
`timescale 1ns/1ps
// Twiddle table: entry k = ROOT^(EXP0 + STEP*k) mod 3329, built at elaboration.
module ntt_sdf_twrom
  import ntt_sdf_pkg::*;
#(
  parameter int TW_NUM  = 1,
  parameter int TW_ROOT = 17,
  parameter int TW_EXP0 = 64,
  parameter int TW_STEP = 32,
  localparam int TWW    = (TW_NUM > 1) ? $clog2(TW_NUM) : 1
) (
  input  logic [TWW-1:0] idx,
  output coef_t          w
);

  localparam int ENTRIES = 1 << TWW;

  coef_t tbl [ENTRIES];

  generate
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
      localparam int unsigned EXP = TW_EXP0 + TW_STEP * k;
      localparam coef_t VAL = coef_t'(mod_pow(TW_ROOT, EXP));
      assign tbl[k] = VAL;
    end
  endgenerate

  assign w = tbl[idx];

endmodule

// File: rtl/ntt_sdf_bfly.sv
`timescale 1ns/1ps
// Behavioural Cooley-Tukey butterfly mod 3329 with LAT pipeline registers.
// y0 = a + w*b, y1 = a - w*b; operands assumed already in 0..3328.
module ntt_sdf_bfly
  import ntt_sdf_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  coef_t a,
  input  coef_t b,
  input  coef_t w,
  input  logic  vin,
  output coef_t y0,
  output coef_t y1,
  output logic  vout
);

  localparam int XS = LAT - 2;

  logic [2*CW-1:0] prod;
  coef_t           a1, m1, y0_2, y1_2;
  logic            v1, v2;
  logic [CW:0]     sum;
  coef_t           y0_n, y1_n;

  assign prod = (2*CW)'(w) * (2*CW)'(b);

  // stage 1: modular product
  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0;
      m1 <= '0;
      v1 <= 1'b0;
    end else if (en) begin
      a1 <= a;
      m1 <= CW'(prod % (2*CW)'(MODQ));
      v1 <= vin;
    end
  end

  assign sum  = {1'b0, a1} + {1'b0, m1};
  assign y0_n = (sum >= (CW+1)'(MODQ)) ? CW'(sum - (CW+1)'(MODQ)) : sum[CW-1:0];
  assign y1_n = (a1 >= m1) ? (a1 - m1)
                           : CW'({1'b0, a1} + (CW+1)'(MODQ) - {1'b0, m1});

  // stage 2: add / subtract with conditional correction
  always_ff @(posedge clk) begin
    if (rst) begin
      y0_2 <= '0;
      y1_2 <= '0;
      v2   <= 1'b0;
    end else if (en) begin
      y0_2 <= y0_n;
      y1_2 <= y1_n;
      v2   <= v1;
    end
  end

  generate
    if (XS == 0) begin : g_nox
      assign y0   = y0_2;
      assign y1   = y1_2;
      assign vout = v2;
    end else begin : g_xtra
      coef_t p0 [XS];
      coef_t p1 [XS];
      logic  pv [XS];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < XS; i++) begin
            p0[i] <= '0;
            p1[i] <= '0;
            pv[i] <= 1'b0;
          end
        end else if (en) begin
          p0[0] <= y0_2;
          p1[0] <= y1_2;
          pv[0] <= v2;
          for (int i = 1; i < XS; i++) begin
            p0[i] <= p0[i-1];
            p1[i] <= p1[i-1];
            pv[i] <= pv[i-1];
          end
        end
      end
      assign y0   = p0[XS-1];
      assign y1   = p1[XS-1];
      assign vout = pv[XS-1];
    end
  endgenerate

endmodule

// File: rtl/ntt_sdf_stage.sv
`timescale 1ns/1ps
// One radix-2 delay-feedback stage with a pipelined butterfly.
module ntt_sdf_stage
  import ntt_sdf_pkg::*;
#(
  parameter int N       = 256,
  parameter int LAT     = 2,
  parameter int TW_NUM  = 1,
  parameter int TW_ROOT = 17,
  parameter int TW_EXP0 = 64,
  parameter int TW_STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  output logic          out_valid,
  output logic [CW-1:0] out_data
);

  localparam int H     = N / 2;
  localparam int LOG2N = $clog2(N);
  localparam int D1    = H - LAT;
  localparam int D3    = H - 2 * LAT;
  localparam int PRIME = H + LAT;
  localparam int PW    = $clog2(PRIME + 1);
  localparam int TWW   = (TW_NUM > 1) ? $clog2(TW_NUM) : 1;

  generate
    if ((1 << LOG2N) != N || LAT < 2 || D3 < 0) begin : g_bad_cfg
      $error("ntt_sdf_stage: N must be a power of two, LAT >= 2, N/2 >= 2*LAT");
    end
  endgenerate

  logic en;
  assign en = in_valid;

  // ---------------- local control ----------------
  logic [LOG2N-1:0] cnt;
  logic [TWW-1:0]   blk;
  logic [PW-1:0]    pcnt;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      blk  <= '0;
      pcnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
      if (cnt == LOG2N'(N - 1)) begin
        blk <= (blk == TWW'(TW_NUM - 1)) ? '0 : blk + 1'b1;
      end
      if (!primed) pcnt <= pcnt + 1'b1;
    end
  end

  assign primed = (pcnt == PW'(PRIME));

  // phase windows, all modulo N via natural wrap
  logic [LOG2N-1:0] ph_f2, ph_out;
  logic             first_in, issue, sel_first, sel_y0;

  assign first_in  = ~cnt[LOG2N-1];             // block phase 0..H-1
  assign issue     =  cnt[LOG2N-1];             // block phase H..N-1
  assign ph_f2     = cnt - LOG2N'(D1);
  assign sel_first = ~ph_f2[LOG2N-1];           // FIFO1 presents first-half data
  assign ph_out    = cnt - LOG2N'(LAT);
  assign sel_y0    =  ph_out[LOG2N-1];          // butterfly sum is due at the output

  // ---------------- twiddle ----------------
  coef_t tw;

  ntt_sdf_twrom #(
    .TW_NUM  (TW_NUM),
    .TW_ROOT (TW_ROOT),
    .TW_EXP0 (TW_EXP0),
    .TW_STEP (TW_STEP)
  ) u_rom (
    .idx (blk),
    .w   (tw)
  );

  // ---------------- delay network ----------------
  logic [CW:0]   f1_q, f3_q;
  coef_t         f2_d, f2_q, f4_q;
  coef_t         bf_y0, bf_y1;
  logic          bf_v;
  logic          fh_live, fb_live;

  // FIFO1: incoming samples, tagged with first-half flag
  ntt_sdf_dline #(.W(CW + 1), .D(D1)) u_f1 (
    .clk (clk), .rst (rst), .en (en),
    .din ({first_in, in_data}),
    .dout(f1_q)
  );

  // FIFO3: butterfly differences, tagged with pair-valid flag
  ntt_sdf_dline #(.W(CW + 1), .D(D3)) u_f3 (
    .clk (clk), .rst (rst), .en (en),
    .din ({bf_v, bf_y1}),
    .dout(f3_q)
  );

  assign fh_live = f1_q[CW];
  assign fb_live = f3_q[CW];
  assign f2_d    = sel_first ? f1_q[CW-1:0] : f3_q[CW-1:0];

  // FIFO2: shared short line, first-half data or feedback by phase
  ntt_sdf_dline #(.W(CW), .D(LAT)) u_f2 (
    .clk (clk), .rst (rst), .en (en),
    .din (f2_d),
    .dout(f2_q)
  );

  // FIFO4: final alignment of feedback
  ntt_sdf_dline #(.W(CW), .D(LAT)) u_f4 (
    .clk (clk), .rst (rst), .en (en),
    .din (f2_q),
    .dout(f4_q)
  );

  // ---------------- butterfly ----------------
  ntt_sdf_bfly #(.LAT(LAT)) u_bf (
    .clk (clk), .rst (rst), .en (en),
    .a   (f2_q),
    .b   (in_data),
    .w   (tw),
    .vin (issue),
    .y0  (bf_y0),
    .y1  (bf_y1),
    .vout(bf_v)
  );

  // ---------------- registered output ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= en & primed;
      if (en && primed) begin
        out_data <= sel_y0 ? bf_y0 : f4_q;
      end
    end
  end

endmodule

// File: rtl/ntt_sdf_stage_chk.sv
`timescale 1ns/1ps
module ntt_sdf_stage_chk #(
  parameter int N   = 256,
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [11:0] out_data,
  input logic        fh_live,
  input logic        fb_live,
  input logic        sel_first
);

  localparam int H = N / 2;

  int acc;
  int warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= 0;
      warm <= 0;
    end else if (in_valid) begin
      if (acc <= H + LAT) acc <= acc + 1;
      if (warm < N) warm <= warm + 1;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == 12'd0));

  // R2
  prime_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc > H + LAT));

  // R6
  stream_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc >= H + LAT) |=> out_valid);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data < 12'd3329));

  // R8
  clash_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && warm >= N) |-> !(fh_live && fb_live));

  // R8
  fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && warm >= N) |-> (fh_live || fb_live));

  // R8
  route_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && warm >= N) |-> (sel_first == fh_live));

endmodule

bind ntt_sdf_stage ntt_sdf_stage_chk #(.N(N), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .fh_live   (fh_live),
  .fb_live   (fb_live),
  .sel_first (sel_first)
);

// File: tb/sim_ntt_sdf_stage.sv
`timescale 1ns/1ps
module sim_ntt_sdf_stage;

  localparam int Q     = 3329;
  localparam int N     = 16;
  localparam int H     = N / 2;
  localparam int LAT   = 2;
  localparam int TWN   = 4;
  localparam int ROOT  = 17;
  localparam int E0    = 64;
  localparam int STEP  = 32;
  localparam int NB    = 12;
  localparam int TOT   = NB * N;
  localparam int GAPB  = 8;    // blocks from here on are sent with idle cycles

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic [11:0] out_data;

  always #4 clk = ~clk;

  ntt_sdf_stage #(
    .N(N), .LAT(LAT), .TW_NUM(TWN), .TW_ROOT(ROOT), .TW_EXP0(E0), .TW_STEP(STEP)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int xin   [TOT];
  int exp_o [TOT];
  int checks = 0;
  int fails  = 0;
  int acc    = 0;     // accepted inputs so far
  int ocnt   = 0;     // valid outputs seen
  bit last_v = 1'b0;
  int last_i = 0;

  function automatic int twid(input int k);
    int r;
    r = 1;
    for (int i = 0; i < E0 + STEP * k; i++) r = (r * ROOT) % Q;
    return r;
  endfunction

  function automatic string tag_of(input int k);
    int b;
    int j;
    b = k / N;
    j = k % N;
    if (b == 1 || b == 5) return "R9";
    if (b >= 4 && (b % TWN) != 0) return "R5";
    if (j < H) return "R3";
    return "R4 R8";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // sample outputs of the previous edge, then drive the next step
  task automatic tick(input bit v, input int d);
    bit ev;
    @(negedge clk);
    ev = last_v && (last_i >= H + LAT);
    if (last_v) chk(out_valid == ev, "R2 R6 out_valid", int'(out_valid), int'(ev));
    else        chk(out_valid == 1'b0, "R7 out_valid after idle", int'(out_valid), 0);
    if (out_valid && ev) begin
      if (ocnt < TOT) begin
        chk(int'(out_data) == exp_o[ocnt], tag_of(ocnt), int'(out_data), exp_o[ocnt]);
      end else begin
        chk(1'b0, "R6 extra output", ocnt, TOT);
      end
      ocnt++;
    end
    in_valid = v;
    in_data  = 12'(d);
    last_v   = v;
    if (v) begin
      last_i = acc;
      acc++;
    end
  endtask

  initial begin
    int seed;
    seed = 12345;
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < N; j++) begin
        int v;
        case (b)
          0:       v = 0;
          1:       v = Q - 1;
          2:       v = (j * 211) % Q;
          3:       v = (j == H) ? 1 : 0;
          4:       v = (j == 0) ? 5 : 0;
          5:       v = (j % 2 == 1) ? Q - 1 : 0;
          default: begin
            seed = (seed * 1103 + 4079) % 65521;
            v = seed % Q;
          end
        endcase
        xin[b*N + j] = v;
      end
      for (int j = 0; j < H; j++) begin
        int w;
        int a;
        int m;
        w = twid(b % TWN);
        a = xin[b*N + j];
        m = (w * xin[b*N + j + H]) % Q;
        exp_o[b*N + j]     = (a + m) % Q;
        exp_o[b*N + j + H] = (a - m + Q) % Q;
      end
    end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_data == 12'd0, "R1 out_data after reset", int'(out_data), 0);

    for (int s = 0; s < TOT; s++) begin
      if (s >= GAPB * N) begin
        if (s % 3 == 1) tick(1'b0, 1234);
        if (s % 7 == 0) begin
          tick(1'b0, 4000);
          tick(1'b0, 77);
        end
      end
      tick(1'b1, xin[s]);
    end
    for (int s = 0; s < H + LAT; s++) tick(1'b1, 0);
    for (int s = 0; s < 3; s++) tick(1'b0, 999);

    chk(ocnt == TOT, "R6 output count", ocnt, TOT);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d outputs", ocnt, TOT);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule